// File: doc/BRIEF.md
# SPI Register-Access Slave Controller

This block lets an external host read and write a 1024-entry space of byte-wide registers over a serial link. Every transaction opens with a 16-bit instruction word. The word carries a direction flag, a byte count and a starting register address, and one to eight data bytes follow it. The host clocks SCLK in SPI mode 0. The block samples input bits on rising SCLK edges and updates its output bit on falling edges. Driving chip select low starts a transaction, and driving it high ends or aborts one.

The serial pins are oversampled in the system clock `clk`. A two-stage synchronizer feeds the edge detection, and the register-file port is therefore fully synchronous. That port provides an address, write data, a one-cycle write strobe, a one-cycle read strobe and a read-data input, which the block samples one cycle after the read strobe.

Two static mode inputs set the wiring and the bit order. In 4-wire mode, read data leaves on a dedicated output pin. In 3-wire mode, read data turns around onto the shared data pin. The bit order is either most significant bit first or least significant bit first. In a multibyte transfer the register address steps down by one per byte in the first ordering and up by one in the second, and it wraps modulo 1024.

FSM states: `ST_IDLE` (deselected), `ST_HDR` (collecting the instruction), `ST_WR` (collecting write bytes), `ST_RD_REQ` (read strobe), `ST_RD_LOAD` (capturing read data), `ST_RD` (shifting a byte out) and `ST_DONE` (all bytes moved, further clocks ignored). The transitions are:
- IDLE→HDR when chip select is seen low.
- HDR→WR or HDR→RD_REQ on the 16th rising edge, chosen by the direction flag.
- WR→WR or WR→DONE on each completed byte.
- RD_REQ→RD_LOAD→RD, unconditionally.
- RD→RD_REQ or RD→DONE on each completed byte.
- Any state→IDLE when chip select is seen high.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `reg_we`, `reg_re`, `sdo_oe` and `sdio_oe` are all low.
- R2: Instruction word fields: bit 15 = 1 for write and 0 for read, bits 14:12 = byte count minus one (1 to 8 bytes), bits 11:10 are ignored, and bits 9:0 = first register address.
- R3: With `cfg_lsb_first` = 0, instruction and data bits travel most significant bit first, and each byte after the first uses the previous address minus one, modulo 1024.
- R4: A write gives exactly one one-cycle `reg_we` pulse per completed data byte, carrying that byte's address and value. Clock edges after the last counted byte cause no further writes.
- R5: With `cfg_lsb_first` = 1, instruction bit 0 and data bit 0 travel first, and each byte after the first uses the previous address plus one, modulo 1024.
- R6: A read gives one one-cycle `reg_re` pulse per byte and captures `reg_rdata` on the next cycle. The byte's first bit is valid before the 17th rising SCLK edge, and the following bits change after falling edges, so the host can sample each one on a rising edge.
- R7: In 3-wire mode, `sdio_oe` rises only after the 16th instruction bit of a read and stays high until chip select is released. It is never high in 4-wire mode or during a write.
- R8: `sdo_oe` is high only while the block is selected in 4-wire mode, and `sdo_o` carries the read bits there. `sdo_oe` is low whenever chip select is high and at all times in 3-wire mode.
- R9: Releasing chip select in the middle of a byte discards that byte with no write, and the next transaction starts with a fresh instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_three_wire | input | 1 | 1 = shared data pin carries read data |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, address increments |
| spi_csn | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| sdio_i | input | 1 | Data pin, input side |
| sdio_o | output | 1 | Data pin, output side (3-wire read data) |
| sdio_oe | output | 1 | Data pin output enable |
| sdo_o | output | 1 | Dedicated read-data pin value |
| sdo_oe | output | 1 | Dedicated read-data pin output enable |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Read data, valid the cycle after `reg_re` |

## Verification
The properties make three assumptions about the inputs. The mode inputs change only while chip select is high. Each SCLK half period lasts at least six `clk` cycles, so the synchronizer latency plus the two-cycle register read finish before the next opposite edge. Chip select never moves in the same `clk` cycle as an SCLK edge. The bench satisfies all three: it changes every pin on the falling `clk` edge, holds each SCLK level for six cycles, puts half a bit period around every chip-select change, and sets the mode inputs only between transactions. The register file that answers reads is a plain bench memory with one-cycle latency, so the stimulus never stalls or back-pressures the port.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WR,
        ST_RD_REQ,
        ST_RD_LOAD,
        ST_RD,
        ST_DONE
    } slv_state_e;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         lsb_first,
    input  logic         din,
    output logic [W-1:0] q_nxt
);
    logic [W-1:0] q;

    // Bits always land in their logical position, whatever the wire order.
    assign q_nxt = lsb_first ? {din, q[W-1:1]} : {q[W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= q_nxt;
    end
endmodule

// File: rtl/spi_txbit.sv
module spi_txbit #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [IW-1:0] idx,
    input  logic          lsb_first,
    output logic          bit_o
);
    assign bit_o = lsb_first ? data[idx] : data[IW'(W-1) - idx];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_slave_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 3,
    parameter int RSV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_three_wire,
    input  logic              cfg_lsb_first,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int HDR_W  = 1 + CNT_W + RSV_W + ADDR_W;
    localparam int BIT_W  = $clog2(HDR_W);
    localparam int DBIT_W = $clog2(DATA_W);

    slv_state_e state, state_nxt;

    // Pin synchronisation and edge detection
    logic csn_s, sclk_s, sdi_s, sclk_q;
    logic selected, sclk_rise, sclk_fall;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn, spi_sclk, sdio_i}),
        .q     ({csn_s, sclk_s, sdi_s})
    );

    assign selected  = ~csn_s;
    assign sclk_rise =  sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s &  sclk_q;

    // Datapath state
    logic [BIT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] cur_addr, step_addr;
    logic [CNT_W-1:0]  bytes_left;
    logic [DATA_W-1:0] tx_byte, data_nxt;
    logic [HDR_W-1:0]  hdr_nxt;
    logic              out_bit, drive_en, tx_bit;

    logic hdr_last, byte_last, hdr_done, data_bit, byte_done;
    logic hdr_is_write;
    logic [CNT_W-1:0]  hdr_count;
    logic [ADDR_W-1:0] hdr_addr;
    logic              hdr_rsv_unused;

    spi_shifter #(.W(HDR_W)) u_hdr_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state == ST_HDR && sclk_rise),
        .lsb_first (cfg_lsb_first),
        .din       (sdi_s),
        .q_nxt     (hdr_nxt)
    );

    spi_shifter #(.W(DATA_W)) u_dat_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state == ST_WR && sclk_rise),
        .lsb_first (cfg_lsb_first),
        .din       (sdi_s),
        .q_nxt     (data_nxt)
    );

    spi_txbit #(.W(DATA_W)) u_txbit (
        .data      (tx_byte),
        .idx       (bit_cnt[DBIT_W-1:0]),
        .lsb_first (cfg_lsb_first),
        .bit_o     (tx_bit)
    );

    assign hdr_is_write   = hdr_nxt[HDR_W-1];
    assign hdr_count      = hdr_nxt[HDR_W-2 -: CNT_W];
    assign hdr_addr       = hdr_nxt[ADDR_W-1:0];
    assign hdr_rsv_unused = ^hdr_nxt[ADDR_W+RSV_W-1:ADDR_W];

    assign hdr_last  = (bit_cnt == BIT_W'(HDR_W-1));
    assign byte_last = (bit_cnt == BIT_W'(DATA_W-1));
    assign hdr_done  = (state == ST_HDR) && sclk_rise && hdr_last;
    assign data_bit  = sclk_rise && (state == ST_WR || state == ST_RD);
    assign byte_done = data_bit && byte_last;
    assign step_addr = cfg_lsb_first ? cur_addr + ADDR_W'(1) : cur_addr - ADDR_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (selected) state_nxt = ST_HDR;
            ST_HDR:     if (hdr_done) state_nxt = hdr_is_write ? ST_WR : ST_RD_REQ;
            ST_WR:      if (byte_done) state_nxt = (bytes_left == '0) ? ST_DONE : ST_WR;
            ST_RD_REQ:  state_nxt = ST_RD_LOAD;
            ST_RD_LOAD: state_nxt = ST_RD;
            ST_RD:      if (byte_done) state_nxt = (bytes_left == '0) ? ST_DONE : ST_RD_REQ;
            ST_DONE:    state_nxt = ST_DONE;
            default:    state_nxt = ST_IDLE;
        endcase
        if (!selected) state_nxt = ST_IDLE;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            bit_cnt    <= '0;
            cur_addr   <= '0;
            bytes_left <= '0;
            tx_byte    <= '0;
            out_bit    <= 1'b0;
            drive_en   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            if (state == ST_IDLE) begin
                bit_cnt  <= '0;
                out_bit  <= 1'b0;
                drive_en <= 1'b0;
            end
            if (hdr_done) begin
                bit_cnt    <= '0;
                cur_addr   <= hdr_addr;
                bytes_left <= hdr_count;
                drive_en   <= ~hdr_is_write;
            end else if (state == ST_HDR && sclk_rise) begin
                bit_cnt <= bit_cnt + BIT_W'(1);
            end else if (data_bit) begin
                bit_cnt <= byte_last ? '0 : bit_cnt + BIT_W'(1);
            end
            if (byte_done) begin
                cur_addr <= step_addr;
                if (bytes_left != '0) bytes_left <= bytes_left - CNT_W'(1);
            end
            if (state == ST_RD_LOAD)           tx_byte <= reg_rdata;
            if (state == ST_RD && sclk_fall)   out_bit <= tx_bit;
        end
    end

    // Outputs
    always_comb begin
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        reg_addr  = cur_addr;
        reg_wdata = data_nxt;
        sdo_oe    = 1'b0;
        unique case (state)
            ST_IDLE:    sdo_oe = 1'b0;
            ST_WR: begin
                reg_we = byte_done && selected;
                sdo_oe = ~cfg_three_wire;
            end
            ST_RD_REQ: begin
                reg_re = 1'b1;
                sdo_oe = ~cfg_three_wire;
            end
            ST_HDR, ST_RD_LOAD, ST_RD, ST_DONE: sdo_oe = ~cfg_three_wire;
            default:    sdo_oe = 1'b0;
        endcase
        sdio_oe = drive_en & cfg_three_wire;
        sdio_o  = out_bit;
        sdo_o   = out_bit;
    end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic spi_csn,
    input logic cfg_three_wire,
    input logic reg_we,
    input logic reg_re,
    input logic sdo_oe,
    input logic sdio_oe
);
    localparam int CW  = $clog2(SYNC_STAGES + 3) + 1;
    localparam int SAT = SYNC_STAGES + 2;

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hi_cnt <= '0;
        else if (!spi_csn)            hi_cnt <= '0;
        else if (hi_cnt != CW'(SAT))  hi_cnt <= hi_cnt + CW'(1);
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R4
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R4
    AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re); // R6
    AST_SDO_HIZ_3W: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_three_wire |-> !sdo_oe); // R8
    AST_SDIO_IN_4W: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_three_wire |-> !sdio_oe); // R7
    AST_CS_HIGH_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt == CW'(SAT)) |-> (!sdo_oe && !sdio_oe)); // R8
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_csn        (spi_csn),
    .cfg_three_wire (cfg_three_wire),
    .reg_we         (reg_we),
    .reg_re         (reg_re),
    .sdo_oe         (sdo_oe),
    .sdio_oe        (sdio_oe)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_three_wire = 1'b0, cfg_lsb_first = 1'b0;
    logic       spi_csn = 1'b1, spi_sclk = 1'b0, sdio_i = 1'b0;
    logic       sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [9:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_we, reg_re;

    always #4 clk = ~clk;

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .cfg_three_wire(cfg_three_wire),
        .cfg_lsb_first(cfg_lsb_first), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o),
        .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // Register file model with one-cycle read latency, plus strobe logs.
    logic [7:0] mem    [1024];
    logic [7:0] shadow [1024];
    int         we_cnt, re_cnt;
    logic [9:0] we_addr_log [16];
    logic [7:0] we_data_log [16];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            if (we_cnt < 16) begin
                we_addr_log[we_cnt] <= reg_addr;
                we_data_log[we_cnt] <= reg_wdata;
            end
            we_cnt <= we_cnt + 1;
        end
        if (reg_re) begin
            reg_rdata <= mem[reg_addr];
            re_cnt    <= re_cnt + 1;
        end
    end

    int nvec = 0, nfail = 0;
    logic [7:0] wbytes [8];
    logic [7:0] rbytes [8];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transaction. abort_at < 0 means run to completion.
    task automatic xfer(input bit tw, input bit lsb, input bit wr, input int cnt,
                        input logic [9:0] addr, input logic [1:0] rsv,
                        input int extra, input int abort_at);
        logic [15:0] hdr;
        int total;
        hdr = {wr, 3'(cnt - 1), rsv, addr};
        total = 16 + 8 * cnt + extra;
        @(negedge clk);
        cfg_three_wire = tw;
        cfg_lsb_first  = lsb;
        we_cnt = 0;
        re_cnt = 0;
        wait_clk(4);
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < total; b++) begin
            int k, j, idx;
            logic v;
            bit rd_phase;
            if (b == abort_at) break;
            rd_phase = !wr && b >= 16 && b < 16 + 8 * cnt;
            if (b < 16) v = hdr[lsb ? b : 15 - b];
            else if (wr && b < 16 + 8 * cnt) begin
                k = (b - 16) / 8; j = (b - 16) % 8;
                v = wbytes[k][lsb ? j : 7 - j];
            end else v = 1'b1;
            sdio_i = rd_phase ? 1'b0 : v;
            wait_clk(HALF);
            if (b == 8) begin
                chk("R7 sdio_oe low during instruction", 32'(sdio_oe), 32'd0);
                chk("R8 sdo_oe while selected", 32'(sdo_oe), 32'(!tw));
            end
            if (rd_phase) begin
                k = (b - 16) / 8; j = (b - 16) % 8;
                idx = lsb ? j : 7 - j;
                rbytes[k][idx] = tw ? sdio_o : sdo_o;
                if (j == 0) begin
                    if (tw) chk("R7 sdio_oe during read data", 32'(sdio_oe), 32'd1);
                    else    chk("R8 sdo_oe during read data", 32'(sdo_oe), 32'd1);
                end
            end
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_csn = 1'b1;
        sdio_i  = 1'b0;
        wait_clk(8);
        chk("R8 sdo_oe released", 32'(sdo_oe), 32'd0);
        chk("R7 sdio_oe released", 32'(sdio_oe), 32'd0);
    endtask

    function automatic logic [9:0] nth_addr(input logic [9:0] a, input bit lsb, input int k);
        return lsb ? 10'(a + 10'(k)) : 10'(a - 10'(k));
    endfunction

    task automatic pair(input bit tw, input bit lsb, input int cnt, input logic [9:0] addr);
        string tag;
        tag = lsb ? "R5" : "R3";
        for (int k = 0; k < cnt; k++)
            wbytes[k] = 8'(addr * 3 + k * 29 + cnt * 7) ^ {6'd0, tw, lsb};
        xfer(tw, lsb, 1'b1, cnt, addr, 2'(cnt), 0, -1);
        chk("R4 write strobe count", 32'(we_cnt), 32'(cnt));
        chk("R2 first write address", 32'(we_addr_log[0]), 32'(addr));
        for (int k = 0; k < cnt; k++) begin
            chk({tag, " write address step"}, 32'(we_addr_log[k]), 32'(nth_addr(addr, lsb, k)));
            chk({tag, " write data order"}, 32'(we_data_log[k]), 32'(wbytes[k]));
            shadow[nth_addr(addr, lsb, k)] = wbytes[k];
        end
        xfer(tw, lsb, 1'b0, cnt, addr, ~2'(cnt), 0, -1);
        chk("R6 read strobe count", 32'(re_cnt), 32'(cnt));
        for (int k = 0; k < cnt; k++)
            chk({"R6 ", tag, " read data"}, 32'(rbytes[k]), 32'(shadow[nth_addr(addr, lsb, k)]));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]    = 8'(i * 37 + 5) ^ 8'(i >> 2);
            shadow[i] = 8'(i * 37 + 5) ^ 8'(i >> 2);
        end
        we_cnt = 0;
        re_cnt = 0;
        reg_rdata = '0;
        wait_clk(5);
        chk("R1 reg_we after reset", 32'(reg_we), 32'd0);
        chk("R1 reg_re after reset", 32'(reg_re), 32'd0);
        chk("R1 sdo_oe after reset", 32'(sdo_oe), 32'd0);
        chk("R1 sdio_oe after reset", 32'(sdio_oe), 32'd0);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 sdo_oe idle", 32'(sdo_oe), 32'd0);

        // Sweep: wiring x ordering x byte count x two start addresses (second wraps).
        for (int m = 0; m < 4; m++) begin
            for (int c = 1; c <= 8; c++) begin
                pair(m[1], m[0], c, 10'(c * 97 + m * 211));
                pair(m[1], m[0], c, m[0] ? 10'd1022 : 10'd1);
            end
        end

        // R4: extra clocks after the counted byte produce no extra write.
        wbytes[0] = 8'h5A;
        xfer(1'b0, 1'b0, 1'b1, 1, 10'd300, 2'b11, 12, -1);
        chk("R4 no write beyond byte count", 32'(we_cnt), 32'd1);
        shadow[300] = 8'h5A;

        // R9: abort inside the second byte keeps only the first.
        wbytes[0] = 8'hC3; wbytes[1] = 8'h3C;
        xfer(1'b1, 1'b1, 1'b1, 2, 10'd500, 2'b00, 0, 16 + 8 + 5);
        chk("R9 partial byte discarded", 32'(we_cnt), 32'd1);
        shadow[500] = 8'hC3;
        xfer(1'b1, 1'b1, 1'b0, 2, 10'd500, 2'b00, 0, -1);
        chk("R9 first byte kept", 32'(rbytes[0]), 32'(shadow[500]));
        chk("R9 aborted byte unchanged", 32'(rbytes[1]), 32'(shadow[501]));

        // R9: abort inside the instruction, then a fresh read works.
        xfer(1'b0, 1'b0, 1'b1, 1, 10'd77, 2'b00, 0, 10);
        chk("R9 no write on header abort", 32'(we_cnt), 32'd0);
        xfer(1'b0, 1'b0, 1'b0, 1, 10'd300, 2'b01, 0, -1);
        chk("R9 fresh transaction read", 32'(rbytes[0]), 32'(shadow[300]));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule